// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one 8-bit bidirectional port of a small microcontroller. Software reaches it through three byte-wide registers. One holds the per-pin direction, one holds the per-pin output value, and one returns the synchronized pad levels. The direction and output bits of each pin together choose one of four pad modes: floating input, input with a weak pull-up, driven low, or driven high. The block produces the pad-side output-enable, output value and pull-up enable for every pin.

An elaboration parameter turns on the special variant of the port. In that variant the two upper output-register bits are not pin bits. Writing a 1 to them requests HALT or IDLE as a single-cycle pulse, and they always read back as zero. The two upper direction bits select the alternate serial-clock phase and the post-HALT clock start-up delay. Pin 6 is forced to a floating input. When the watchdog strap is set, pin 1 carries the watchdog level with a weak pull-up. When the crystal strap is set, pin 7 carries the oscillator clock. Otherwise pin 7 is a floating input, and a rising edge on it raises a wake event. A second parameter selects a port type that leaves reset with every pin driven high.

Top module: `gpio_port_ctrl`

## Requirements
- R1: On reset the direction and output registers clear to 0, so every pin is a floating input (pad_oe=0, pad_pu=0).
- R2: Register offsets are bus_addr 0 = direction, 1 = output value, 2 = synchronized pin levels (read only; writes there change nothing), and 3 reads as 0. Reads are combinational.
- R3: Per pin, with direction bit d and output bit v: d=0,v=0 floats (oe=0, pu=0); d=0,v=1 is a pulled-up input (oe=0, pu=1); d=1,v=0 drives 0 (oe=1, out=0, pu=0); d=1,v=1 drives 1 (oe=1, out=1, pu=0).
- R4: The pin-level register samples pad_in through two flops. A pad change made between edges shows on the read after the second rising edge and not after the first.
- R5: In the special variant, a write to offset 1 with bit 7 set gives halt_req=1 for exactly the cycle after the write edge, and bit 6 does the same for idle_req. A write with these bits clear gives no pulse.
- R6: In the special variant, bits 7 and 6 of the output register always read as 0.
- R7: In the special variant, alt_sk_phase follows direction bit 6 and clk_dly_en follows direction bit 7. Both bits read back as written.
- R8: In the special variant, pin 6 is always a floating input (oe=0, pu=0), whatever its register bits hold.
- R9: In the special variant with opt_wdog=1, pin 1 has pu=1 and out=0, and is driven (oe=1) exactly when wdog_level=0. Its register bits have no effect. With opt_wdog=0, pin 1 follows R3.
- R10: In the special variant with opt_xtal=1, pin 7 has oe=1 and out=osc_clk. With opt_xtal=0 it is a floating input.
- R11: In the special variant with opt_xtal=0, a 0-to-1 change of the synchronized pin-7 level raises wake_evt for one cycle, in the same cycle the new level first reads back. A falling edge, or any edge while opt_xtal=1, raises nothing.
- R12: With RESET_HIGH=1, the direction and output registers reset to all ones, so every pin drives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr |
| pad_in | input | W | Pad input levels |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Pad output value |
| pad_pu | output | W | Pad weak pull-up enable |
| opt_wdog | input | 1 | Strap: pin 1 carries the watchdog output |
| opt_xtal | input | 1 | Strap: pin 7 carries the oscillator clock |
| wdog_level | input | 1 | Watchdog output level for pin 1 |
| osc_clk | input | 1 | Oscillator clock for pin 7 |
| halt_req | output | 1 | One-cycle HALT request pulse |
| idle_req | output | 1 | One-cycle IDLE request pulse |
| wake_evt | output | 1 | One-cycle wake event from a pin 7 rising edge |
| alt_sk_phase | output | 1 | Alternate serial-clock phase select |
| clk_dly_en | output | 1 | Clock start-up delay after HALT enable |

## Verification
On every cycle, the assertions check these properties: the HALT, IDLE and wake outputs stay single-cycle and HALT has a matching write one cycle earlier; the output register always reads zero in its upper bits and offset 3 always reads zero; pin 6 never drives or pulls; the strapped pins 1 and 7 follow the watchdog level and the oscillator clock; and no ordinary pin drives and pulls up at the same time. Other behaviour can only be shown by the bench's scenarios. This covers the exact pad mode for each direction and output pair, the two-edge latency of the pin read, the reset values of both port types, and the fact that register bits written under a strap and writes to the pin-level offset change nothing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [1:0] OFF_CFG = 2'd0;
  localparam logic [1:0] OFF_DAT = 2'd1;
  localparam logic [1:0] OFF_PIN = 2'd2;

  localparam int PIN_WDOG   = 1;
  localparam int PIN_INONLY = 6;
  localparam int PIN_OSC    = 7;
  localparam int BIT_IDLE   = 6;
  localparam int BIT_HALT   = 7;
  localparam int BIT_ALTSK  = 6;
  localparam int BIT_CLKDLY = 7;

  typedef enum logic [1:0] {
    PM_FLOAT  = 2'b00,
    PM_PULLUP = 2'b01,
    PM_DRV0   = 2'b10,
    PM_DRV1   = 2'b11
  } pad_mode_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pad_ctl_t;

  function automatic pad_ctl_t pad_decode(input logic dir_bit, input logic val_bit);
    pad_ctl_t c;
    c = '0;
    case (pad_mode_e'({dir_bit, val_bit}))
      PM_FLOAT:  c = '0;
      PM_PULLUP: c.pu = 1'b1;
      PM_DRV0:   c.oe = 1'b1;
      PM_DRV1:   begin c.oe = 1'b1; c.out = 1'b1; end
      default:   c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_bits,
  input  logic [W-1:0] val_bits,
  output logic [W-1:0] oe,
  output logic [W-1:0] out,
  output logic [W-1:0] pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_ctl_t ctl;
    assign ctl    = pad_decode(dir_bits[i], val_bits[i]);
    assign oe[i]  = ctl.oe;
    assign out[i] = ctl.out;
    assign pu[i]  = ctl.pu;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter bit SPECIAL     = 1'b1,
  parameter bit RESET_HIGH  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  input  logic         opt_wdog,
  input  logic         opt_xtal,
  input  logic         wdog_level,
  input  logic         osc_clk,
  output logic         halt_req,
  output logic         idle_req,
  output logic         wake_evt,
  output logic         alt_sk_phase,
  output logic         clk_dly_en
);
  localparam logic [W-1:0] CTRL_BITS = SPECIAL ?
    ((W'(1) << BIT_HALT) | (W'(1) << BIT_IDLE)) : '0;
  localparam logic [W-1:0] DAT_KEEP = ~CTRL_BITS;
  localparam logic [W-1:0] RST_VAL  = {W{RESET_HIGH}};

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  // register next-state
  logic         wr_cfg, wr_dat;
  logic [W-1:0] cfg_q, cfg_d, dat_q, dat_d;
  logic         halt_q, halt_d, idle_q, idle_d;
  logic         prev7_q, prev7_d;
  logic [W-1:0] pin_sync;

  assign wr_cfg = bus_wr && (bus_addr == OFF_CFG);
  assign wr_dat = bus_wr && (bus_addr == OFF_DAT);

  always_comb begin
    cfg_d   = bus_wdata;
    dat_d   = bus_wdata & DAT_KEEP;
    halt_d  = SPECIAL && wr_dat && bus_wdata[BIT_HALT];
    idle_d  = SPECIAL && wr_dat && bus_wdata[BIT_IDLE];
    prev7_d = pin_sync[PIN_OSC];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q   <= RST_VAL;
      dat_q   <= RST_VAL & DAT_KEEP;
      halt_q  <= 1'b0;
      idle_q  <= 1'b0;
      prev7_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_d;
      if (wr_dat) dat_q <= dat_d;
      halt_q  <= halt_d;
      idle_q  <= idle_d;
      prev7_q <= prev7_d;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  always_comb begin
    case (bus_addr)
      OFF_CFG: bus_rdata = cfg_q;
      OFF_DAT: bus_rdata = dat_q;
      OFF_PIN: bus_rdata = pin_sync;
      default: bus_rdata = '0;
    endcase
  end

  logic [W-1:0] base_oe, base_out, base_pu;
  gpio_pad_map #(.W(W)) u_map (
    .dir_bits (cfg_q),
    .val_bits (dat_q),
    .oe       (base_oe),
    .out      (base_out),
    .pu       (base_pu)
  );

  if (SPECIAL) begin : g_special
    always_comb begin
      pad_oe  = base_oe;
      pad_out = base_out;
      pad_pu  = base_pu;
      pad_oe[PIN_INONLY]  = 1'b0;
      pad_out[PIN_INONLY] = 1'b0;
      pad_pu[PIN_INONLY]  = 1'b0;
      if (opt_wdog) begin
        pad_oe[PIN_WDOG]  = ~wdog_level;
        pad_out[PIN_WDOG] = 1'b0;
        pad_pu[PIN_WDOG]  = 1'b1;
      end
      pad_oe[PIN_OSC]  = opt_xtal;
      pad_out[PIN_OSC] = opt_xtal & osc_clk;
      pad_pu[PIN_OSC]  = 1'b0;
    end
    assign wake_evt     = ~opt_xtal & pin_sync[PIN_OSC] & ~prev7_q;
    assign alt_sk_phase = cfg_q[BIT_ALTSK];
    assign clk_dly_en   = cfg_q[BIT_CLKDLY];
  end else begin : g_plain
    assign pad_oe       = base_oe;
    assign pad_out      = base_out;
    assign pad_pu       = base_pu;
    assign wake_evt     = 1'b0;
    assign alt_sk_phase = 1'b0;
    assign clk_dly_en   = 1'b0;
  end

  assign halt_req = halt_q;
  assign idle_req = idle_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int W       = 8,
  parameter bit SPECIAL = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_pu,
  input logic         opt_wdog,
  input logic         opt_xtal,
  input logic         wdog_level,
  input logic         osc_clk,
  input logic         halt_req,
  input logic         idle_req,
  input logic         wake_evt
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R2

  if (SPECIAL) begin : g_sp
    localparam logic [W-1:0] PLAIN = ~((W'(1) << PIN_WDOG) | (W'(1) << PIN_INONLY) | (W'(1) << PIN_OSC));

    AST_NO_DRIVE_AND_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_pu & PLAIN) == '0)); // R3
    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> !halt_req); // R5
    AST_HALT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(bus_wr && (bus_addr == OFF_DAT) && bus_wdata[BIT_HALT])); // R5
    AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_req |=> !idle_req); // R5
    AST_DAT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFF_DAT) |-> (bus_rdata[BIT_HALT] == 1'b0 && bus_rdata[BIT_IDLE] == 1'b0)); // R6
    AST_PIN6_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!pad_oe[PIN_INONLY] && !pad_pu[PIN_INONLY])); // R8
    AST_WDOG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      opt_wdog |-> (pad_pu[PIN_WDOG] && !pad_out[PIN_WDOG] && (pad_oe[PIN_WDOG] == !wdog_level))); // R9
    AST_XTAL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      opt_xtal |-> (pad_oe[PIN_OSC] && (pad_out[PIN_OSC] == osc_clk))); // R10
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> !wake_evt); // R11
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W), .SPECIAL(SPECIAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_pu     (pad_pu),
  .opt_wdog   (opt_wdog),
  .opt_xtal   (opt_xtal),
  .wdog_level (wdog_level),
  .osc_clk    (osc_clk),
  .halt_req   (halt_req),
  .idle_req   (idle_req),
  .wake_evt   (wake_evt)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bus_wr, opt_wdog, opt_xtal, wdog_level, osc_clk;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pad_in, pad_oe, pad_out, pad_pu;
  logic       halt_req, idle_req, wake_evt, alt_sk_phase, clk_dly_en;

  logic [1:0] hi_addr;
  logic [7:0] hi_rdata, hi_oe, hi_out, hi_pu;
  logic       hi_halt, hi_idle, hi_wake, hi_alt, hi_dly;

  int n_chk = 0;
  int n_bad = 0;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .opt_wdog(opt_wdog), .opt_xtal(opt_xtal), .wdog_level(wdog_level),
    .osc_clk(osc_clk), .halt_req(halt_req), .idle_req(idle_req),
    .wake_evt(wake_evt), .alt_sk_phase(alt_sk_phase), .clk_dly_en(clk_dly_en)
  );

  gpio_port_ctrl #(.SPECIAL(1'b0), .RESET_HIGH(1'b1)) uut_hi (
    .clk(clk), .rst_n(rst_n), .bus_wr(1'b0), .bus_addr(hi_addr),
    .bus_wdata(8'h00), .bus_rdata(hi_rdata), .pad_in(8'h00),
    .pad_oe(hi_oe), .pad_out(hi_out), .pad_pu(hi_pu),
    .opt_wdog(1'b0), .opt_xtal(1'b0), .wdog_level(1'b0),
    .osc_clk(1'b0), .halt_req(hi_halt), .idle_req(hi_idle),
    .wake_evt(hi_wake), .alt_sk_phase(hi_alt), .clk_dly_en(hi_dly)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); check("R1 cfg reset", v, 8'h00);
    rd_reg(2'd1, v); check("R1 data reset", v, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);
    check("R1 pu reset", pad_pu, 8'h00);
    check("R1 no pulses", {halt_req, idle_req, wake_evt}, 3'b000);
    hi_addr = 2'd0; #1;
    check("R12 cfg reset high", hi_rdata, 8'hFF);
    hi_addr = 2'd1; #1;
    check("R12 data reset high", hi_rdata, 8'hFF);
    check("R12 oe high", hi_oe, 8'hFF);
    check("R12 out high", hi_out, 8'hFF);
    check("R12 pu off", hi_pu, 8'h00);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    wr_reg(2'd0, 8'h31);
    wr_reg(2'd1, 8'h29);
    #1;
    check("R3 oe pattern A", pad_oe & 8'h3F, 8'h31);
    check("R3 pu pattern A", pad_pu & 8'h3F, 8'h08);
    check("R3 out pattern A", pad_out & pad_oe & 8'h3F, 8'h21);
    rd_reg(2'd0, v); check("R2 cfg readback", v, 8'h31);
    rd_reg(2'd1, v); check("R2 data readback", v, 8'h29);
    wr_reg(2'd0, 8'h0E);
    wr_reg(2'd1, 8'h34);
    #1;
    check("R3 oe pattern B", pad_oe & 8'h3F, 8'h0E);
    check("R3 pu pattern B", pad_pu & 8'h3F, 8'h30);
    check("R3 out pattern B", pad_out & pad_oe & 8'h3F, 8'h04);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr_reg(2'd2, 8'hAA);
    rd_reg(2'd0, v); check("R2 pin write keeps cfg", v, 8'h0E);
    rd_reg(2'd1, v); check("R2 pin write keeps data", v, 8'h34);
    rd_reg(2'd2, v); check("R2 pin reads pads", v, 8'h00);
    rd_reg(2'd3, v); check("R2 offset 3 zero", v, 8'h00);
  endtask

  task automatic t_halt_idle();
    logic [7:0] v;
    wr_reg(2'd1, 8'hB4);
    #1;
    check("R5 halt pulse", {halt_req, idle_req}, 2'b10);
    rd_reg(2'd1, v); check("R6 data hi bits zero", v, 8'h34);
    @(negedge clk); #1;
    check("R5 halt single cycle", halt_req, 1'b0);
    wr_reg(2'd1, 8'h74);
    #1;
    check("R5 idle pulse", {halt_req, idle_req}, 2'b01);
    @(negedge clk); #1;
    check("R5 idle single cycle", idle_req, 1'b0);
    wr_reg(2'd1, 8'h34);
    #1;
    check("R5 no pulse on clear bits", {halt_req, idle_req}, 2'b00);
  endtask

  task automatic t_cfg_hi();
    logic [7:0] v;
    wr_reg(2'd0, 8'h4E);
    #1;
    check("R7 alt phase set", {alt_sk_phase, clk_dly_en}, 2'b10);
    rd_reg(2'd0, v); check("R7 cfg readback", v, 8'h4E);
    wr_reg(2'd0, 8'h8E);
    #1;
    check("R7 clk delay set", {alt_sk_phase, clk_dly_en}, 2'b01);
  endtask

  task automatic t_pin6();
    logic [7:0] v;
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    @(negedge clk); #1;
    check("R8 pin6 float", {pad_oe[6], pad_pu[6]}, 2'b00);
    check("R10 pin7 float no strap", {pad_oe[7], pad_pu[7]}, 2'b00);
    check("R3 low pins drive 1", pad_oe & pad_out & 8'h3F, 8'h3F);
    rd_reg(2'd1, v); check("R6 data after FF", v, 8'h3F);
  endtask

  task automatic t_wdog();
    opt_wdog = 1'b1; wdog_level = 1'b0; #1;
    check("R9 wdog low drives", {pad_oe[1], pad_out[1], pad_pu[1]}, 3'b101);
    wdog_level = 1'b1; #1;
    check("R9 wdog high pulled", {pad_oe[1], pad_out[1], pad_pu[1]}, 3'b001);
    opt_wdog = 1'b0; #1;
    check("R9 no strap follows regs", {pad_oe[1], pad_out[1], pad_pu[1]}, 3'b110);
  endtask

  task automatic t_xtal();
    opt_xtal = 1'b1; osc_clk = 1'b1; #1;
    check("R10 xtal out 1", {pad_oe[7], pad_out[7]}, 2'b11);
    osc_clk = 1'b0; #1;
    check("R10 xtal out 0", {pad_oe[7], pad_out[7]}, 2'b10);
    opt_xtal = 1'b0; #1;
    check("R10 strap off floats", pad_oe[7], 1'b0);
  endtask

  task automatic t_sync_wake();
    logic [7:0] v;
    @(negedge clk);
    pad_in = 8'h85;
    @(negedge clk);
    rd_reg(2'd2, v); check("R4 not after first edge", v, 8'h00);
    check("R11 no early wake", wake_evt, 1'b0);
    @(negedge clk);
    rd_reg(2'd2, v); check("R4 after second edge", v, 8'h85);
    check("R11 wake on rise", wake_evt, 1'b1);
    @(negedge clk); #1;
    check("R11 wake single cycle", wake_evt, 1'b0);
    pad_in = 8'h05;
    @(negedge clk); @(negedge clk); #1;
    check("R11 no wake on fall", wake_evt, 1'b0);
    @(negedge clk);
    opt_xtal = 1'b1;
    pad_in = 8'h85;
    @(negedge clk); @(negedge clk); #1;
    check("R11 no wake with xtal", wake_evt, 1'b0);
    @(negedge clk);
    opt_xtal = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pad_in = 8'h00; opt_wdog = 1'b0; opt_xtal = 1'b0;
    wdog_level = 1'b1; osc_clk = 1'b0; hi_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_modes();
    t_regmap();
    t_halt_idle();
    t_cfg_hi();
    t_pin6();
    t_wdog();
    t_xtal();
    t_sync_wake();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule